// File: doc/BRIEF.md
# Signed/Unsigned Fractional Multiplier Unit

This unit multiplies two 8-bit operands and returns a 16-bit product with a fixed latency of two clock edges. A 3-bit mode selects how the operands are read: both unsigned, both two's complement, or the first operand two's complement and the second unsigned. Each of these forms also has a fractional variant, in which the 16-bit result is the product shifted left by one bit, as used for 1.7 fixed-point arithmetic.

Two status flags come out with the result: a carry flag that takes the top bit of the product before any shift, and a zero flag that reports an all-zero 16-bit result. A one-cycle done strobe marks the cycle in which product and flags are new. The product, zero and carry outputs hold their values until the next done. The unit accepts a new start every second cycle; the surrounding datapath takes the high byte from product[15:8] and the low byte from product[7:0].

Top module: `fmul_unit`

## Requirements
- R1: After a synchronous active-low reset, done, z, c and product are all 0.
- R2: With mode[1:0] = 00 both operands are unsigned and product is (a*b) mod 2^16.
- R3: With mode[1:0] = 01 both operands are two's complement and product is the low 16 bits of the signed product.
- R4: With mode[1:0] = 10 operand a is two's complement and operand b is unsigned; product is the low 16 bits of that product.
- R5: With mode[2] = 1 the result is the 16-bit integer product shifted left by one with bit 15 dropped and bit 0 cleared; mode[2] = 0 gives the integer product unchanged. Signed fractional 0x80 by 0x80 gives 0x8000.
- R6: c equals bit 15 of the integer product before any shift, in every mode.
- R7: z is 1 exactly when the 16-bit result, after any shift, is zero.
- R8: A start sampled at clock edge N causes done to be 1 for exactly the one cycle after edge N+1, with product, z and c valid in that cycle; done is 0 in the cycle after edge N.
- R9: A start in the cycle right after an accepted start is ignored: it yields no done pulse and does not alter the result.
- R10: Outside a done cycle, product, z and c keep their last values whatever the inputs do.
- R11: mode[1:0] = 11 is treated as unsigned by unsigned, in both integer and fractional form.
- R12: A start presented in the cycle where done is high is accepted and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation on a, b, mode |
| mode | input | 3 | [1:0] operand kind, [2] fractional |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| product | output | 16 | Result, high byte in [15:8], low byte in [7:0] |
| z | output | 1 | Zero flag of the result |
| c | output | 1 | Carry flag, bit 15 of the unshifted product |
| done | output | 1 | One-cycle strobe, result valid |

## Verification
The completion of one operation (done high, result register loading) and the acceptance of the next start can fall in the same cycle. The bench provokes this by raising start with fresh operands in the very cycle it observes done, and judges it by checking that the old result is intact in that cycle and that the new result, from the new operands and mode, appears exactly two edges later. It also holds start high across the busy cycle to confirm that only the first request counts.

// File: rtl/fmul_pkg.sv
// Package: shared mode encoding for the fractional multiplier.
// Assumes mode[1:0] selects operand kind and mode[2] selects fractional.
package fmul_pkg;

    typedef enum logic [1:0] {
        KIND_UU  = 2'b00,
        KIND_SS  = 2'b01,
        KIND_SU  = 2'b10,
        KIND_RSV = 2'b11
    } mul_kind_e;

    typedef struct packed {
        logic      frac;
        mul_kind_e kind;
    } mul_mode_t;

endpackage

// File: rtl/fmul_operand_ext.sv
// Module: extends one operand by a bit so that a single signed multiplier
// covers both unsigned and two's complement readings.
// Assumes as_signed is stable with val.
module fmul_operand_ext #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic         as_signed,
    output logic [W:0]   ext
);

    // Copy the sign bit only when the operand is read as signed.
    always_comb begin
        ext = {as_signed & val[W-1], val};
    end

endmodule

// File: rtl/fmul_core.sv
// Module: first pipeline stage. Captures extended operands and the
// fractional select on load, and forms the integer product from them.
// Assumes load is only raised when the stage is free (gated by the top).
module fmul_core #(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W:0]    a_ext,
    input  logic [W:0]    b_ext,
    input  logic          frac_in,
    output logic          stage_vld,
    output logic [PW-1:0] raw,
    output logic          frac_q
);

    logic [W:0]           a_q;
    logic [W:0]           b_q;
    logic signed [PW-1:0] full;

    // Capture operands and mark the stage occupied for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q       <= '0;
            b_q       <= '0;
            frac_q    <= 1'b0;
            stage_vld <= 1'b0;
        end else begin
            stage_vld <= load;
            if (load) begin
                a_q    <= a_ext;
                b_q    <= b_ext;
                frac_q <= frac_in;
            end
        end
    end

    // Signed multiply of the extended operands, kept to 2W bits.
    always_comb begin
        full = $signed(a_q) * $signed(b_q);
        raw  = full;
    end

    // R9
    busy_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_vld |=> !stage_vld);

endmodule

// File: rtl/fmul_flags.sv
// Module: applies the optional fractional shift and derives Z and C.
// Assumes raw is the 2W-bit integer product.
module fmul_flags #(
    parameter int W     = 8,
    parameter int SHIFT = 1,
    localparam int PW   = 2 * W
) (
    input  logic [PW-1:0] raw,
    input  logic          frac,
    output logic [PW-1:0] result,
    output logic          zf,
    output logic          cf
);

    logic [PW-1:0] shifted;

    generate
        if (SHIFT > 0) begin : g_shift
            // Fractional form drops the top bits and fills with zeros.
            always_comb shifted = raw << SHIFT;
        end else begin : g_noshift
            // No fractional form configured: pass through.
            always_comb shifted = raw;
        end
    endgenerate

    // Pick the form and compute the flags on the chosen result.
    always_comb begin
        result = frac ? shifted : raw;
        cf     = raw[PW-1];
        zf     = (result == '0);
    end

endmodule

// File: rtl/fmul_unit.sv
// Module: top of the signed/unsigned fractional multiplier. A start is
// accepted when the first stage is free; the result, flags and done are
// registered one edge later, giving a two-edge latency.
// Assumes inputs are synchronous to clk.
module fmul_unit #(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [PW-1:0] product,
    output logic          z,
    output logic          c,
    output logic          done
);
    import fmul_pkg::*;

    mul_mode_t     md;
    logic          a_sgn;
    logic          b_sgn;
    logic [W:0]    a_ext;
    logic [W:0]    b_ext;
    logic          accept;
    logic          stage_vld;
    logic [PW-1:0] raw;
    logic          frac_q;
    logic [PW-1:0] result;
    logic          zf;
    logic          cf;
    logic          frac_out;

    // Decode mode into per-operand signedness; reserved kind reads unsigned.
    always_comb begin
        md    = mul_mode_t'(mode);
        a_sgn = (md.kind == KIND_SS) || (md.kind == KIND_SU);
        b_sgn = (md.kind == KIND_SS);
    end

    // Accept a start only when the first stage is empty.
    always_comb accept = start && !stage_vld;

    fmul_operand_ext #(.W(W)) u_ext_a (.val(a), .as_signed(a_sgn), .ext(a_ext));
    fmul_operand_ext #(.W(W)) u_ext_b (.val(b), .as_signed(b_sgn), .ext(b_ext));

    fmul_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .a_ext     (a_ext),
        .b_ext     (b_ext),
        .frac_in   (md.frac),
        .stage_vld (stage_vld),
        .raw       (raw),
        .frac_q    (frac_q)
    );

    fmul_flags #(.W(W), .SHIFT(1)) u_flags (
        .raw    (raw),
        .frac   (frac_q),
        .result (result),
        .zf     (zf),
        .cf     (cf)
    );

    // Register result and flags when stage one completes; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            product  <= '0;
            z        <= 1'b0;
            c        <= 1'b0;
            done     <= 1'b0;
            frac_out <= 1'b0;
        end else begin
            done <= stage_vld;
            if (stage_vld) begin
                product  <= result;
                z        <= zf;
                c        <= cf;
                frac_out <= frac_q;
            end
        end
    end

    // R8
    done_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 done);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    hold_between_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(product) && $stable(z) && $stable(c)));

    // R5
    frac_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frac_out) |-> !product[0]);

    // R7
    z_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (z == (product == '0)));

endmodule

// File: tb/fmul_unit_bench.sv
`timescale 1ns/1ps
module fmul_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [7:0]  a = '0;
    logic [7:0]  b = '0;
    logic [15:0] product;
    logic        z;
    logic        c;
    logic        done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    fmul_unit u_fmul_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .a(a), .b(b), .product(product), .z(z), .c(c), .done(done)
    );

    // Expected {z, c, product} from the requirements.
    function automatic logic [17:0] model(input logic [2:0] md,
                                          input logic [7:0] x,
                                          input logic [7:0] y);
        int xv, yv, p;
        logic [15:0] rawv, res;
        xv = int'(x);
        yv = int'(y);
        if (md[1:0] == 2'b01 || md[1:0] == 2'b10) xv = int'($signed(x));
        if (md[1:0] == 2'b01) yv = int'($signed(y));
        p    = xv * yv;
        rawv = p[15:0];
        res  = md[2] ? {rawv[14:0], 1'b0} : rawv;
        return {(res == 16'h0), rawv[15], res};
    endfunction

    task automatic check(input string req, input logic [17:0] act,
                         input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation and check done timing and the result.
    task automatic run_op(input logic [2:0] md, input logic [7:0] x,
                          input logic [7:0] y, input string req);
        logic [17:0] exp;
        exp = model(md, x, y);
        @(negedge clk);
        start = 1'b1; mode = md; a = x; b = y;
        @(negedge clk);
        start = 1'b0; a = ~x; b = ~y; mode = ~md;
        check("R8 busy cycle", {17'd0, done}, 18'd0);
        @(negedge clk);
        check("R8 done", {17'd0, done}, 18'd1);
        check(req, {z, c, product}, exp);
    endtask

    initial begin
        logic [17:0] e1, e2, held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {done, z, c, product}, 19'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {done, z, c, product}, 19'd0);

        run_op(3'b000, 8'hFF, 8'hFF, "R2 uu max");
        run_op(3'b000, 8'h12, 8'h34, "R2 uu");
        run_op(3'b001, 8'h80, 8'h80, "R3 ss 80x80");
        run_op(3'b001, 8'hFF, 8'h02, "R3 ss -1x2");
        run_op(3'b010, 8'hFF, 8'hFF, "R4 R6 su -1x255");
        run_op(3'b010, 8'h7F, 8'hFF, "R4 su pos");
        run_op(3'b101, 8'h80, 8'h80, "R5 R6 ss frac 80x80");
        run_op(3'b100, 8'hC0, 8'hC0, "R5 R6 uu frac carry");
        run_op(3'b110, 8'h80, 8'h7F, "R5 su frac");
        run_op(3'b000, 8'h00, 8'h55, "R7 zero");
        run_op(3'b101, 8'h00, 8'h80, "R7 frac zero");
        run_op(3'b011, 8'hFF, 8'hFF, "R11 reserved");
        run_op(3'b111, 8'hF0, 8'h0F, "R11 reserved frac");

        // R10: outputs hold while inputs move without start
        held = {z, c, product};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            a = 8'($urandom); b = 8'($urandom); mode = 3'($urandom);
            check("R10 hold", {done, z, c, product}, {1'b0, held});
        end

        // R9: start held across busy cycle; second request ignored
        e1 = model(3'b001, 8'h90, 8'h33);
        @(negedge clk);
        start = 1'b1; mode = 3'b001; a = 8'h90; b = 8'h33;
        @(negedge clk);
        mode = 3'b000; a = 8'h05; b = 8'h07;
        @(negedge clk);
        start = 1'b0;
        check("R9 first done", {done, z, c, product}, {1'b1, e1});
        @(negedge clk);
        check("R9 no extra done", {done, z, c, product}, {1'b0, e1});
        @(negedge clk);
        check("R9 still idle", {done, z, c, product}, {1'b0, e1});

        // R12: start in the done cycle is accepted
        e1 = model(3'b010, 8'hA5, 8'h5A);
        e2 = model(3'b100, 8'h3C, 8'hC3);
        @(negedge clk);
        start = 1'b1; mode = 3'b010; a = 8'hA5; b = 8'h5A;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R12 first done", {done, z, c, product}, {1'b1, e1});
        start = 1'b1; mode = 3'b100; a = 8'h3C; b = 8'hC3;
        @(negedge clk);
        start = 1'b0;
        check("R12 old kept", {done, z, c, product}, {1'b0, e1});
        @(negedge clk);
        check("R12 second done", {done, z, c, product}, {1'b1, e2});

        // Random operations across all modes
        for (int i = 0; i < 300; i++) begin
            logic [2:0] rm;
            rm = 3'($urandom);
            run_op(rm, 8'($urandom), 8'($urandom), "R2 R3 R4 R5 R6 R7 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule